// File: doc/BRIEF.md
# IDE DMA Transfer Sequencer

This block steers one DMA transfer between an IDE drive and a descriptor-driven DMA channel. A start pulse from the drive side captures the drive type, the command and the starting block address. It also loads the total byte count: the packet size for an optical drive, or the sector count times 512 for a disk. The block then sets its active flag and pulses a kick to the channel.

The channel then hands over descriptors (address plus length) one at a time. For each descriptor the sequencer works out the byte offset on the medium, reduces the remaining count, advances its buffer index and issues a single request on the medium port. It waits for the acknowledge before taking any further descriptor. A transfer ends in one of three ways: a completion (drive status ready with seek done and an interrupt for a disk, a packet-success pulse for an optical drive), an error report, or a descriptor-done that leaves the transfer open.

An optical transfer whose block address is all ones is treated as a non-block packet transfer. It is moved with one direct copy request. A descriptor that arrives before the block is active is parked, and the channel offers it again after the next kick.

Top module: `ide_dma_seq`

## Requirements
- R1: After a synchronous reset, every output is low: strobes, busy, med_req, fatal, and drv_status (which reads 0x00).
- R2: A start pulse accepted while no request is pending does three things. It pulses kick one cycle later and raises busy. It loads the remaining count with pkt_bytes for an optical drive or sec_count*512 for a disk, and it clears the buffer index.
- R3: A descriptor is parked, with a one-cycle desc_park and no request or desc_done, in two cases: the block is not active, or the descriptor arrives in the same cycle as a start pulse (start takes priority).
- R4: A descriptor, or a medium acknowledge, seen while the remaining count is zero or negative completes the transfer. Completion clears the active flag, pulses desc_done and drops busy. A disk also sets drv_status to 0x50 and pulses irq; an optical drive pulses pkt_ok instead.
- R5: A zero-length descriptor seen while active with a positive remaining count pulses desc_done and drops busy. It issues no request and keeps the block active.
- R6: The request offset is start_sector*512 plus the buffer index for a disk, and pkt_lba*2048 plus the buffer index for an optical drive.
- R7: Each block request carries the descriptor address and length. Its length is subtracted from the remaining count and added to the buffer index.
- R8: med_op is 0 for read, 1 for write, 2 for trim and 3 for a direct copy. A disk takes cmd codes 0 (read), 1 (write) and 2 (trim) unchanged. Optical block requests are always reads.
- R9: A descriptor serviced for a disk whose cmd is 3 raises fatal. Fatal stays high, and the block ignores all inputs until reset.
- R10: If pkt_lba is all ones on an optical drive, the block issues one copy request of length min(remaining, descriptor length). Its acknowledge pulses pkt_ok and desc_done and clears the active flag.
- R11: An acknowledge with med_err pulses dma_err (disk) or pkt_err (optical), together with desc_done. It drops busy and clears the active flag.
- R12: Only one request is outstanding. med_req and its fields hold until med_ack, and desc_done follows the acknowledge by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Drive begins DMA (one-cycle pulse) |
| is_optical | input | 1 | 1 = optical drive, 0 = disk |
| cmd | input | 2 | Disk command: 0 read, 1 write, 2 trim, 3 illegal |
| sec_count | input | NSEC_W | Disk sector count |
| pkt_bytes | input | PKT_W | Optical packet transfer size in bytes |
| start_sector | input | LBA_W | Disk starting sector |
| pkt_lba | input | LBA_W | Optical block address, all ones = not block addressed |
| desc_valid | input | 1 | Channel presents a descriptor (one-cycle pulse) |
| desc_addr | input | ADDR_W | Descriptor memory address |
| desc_len | input | LEN_W | Descriptor length in bytes |
| kick | output | 1 | Pulse telling the channel to (re)start |
| desc_done | output | 1 | Descriptor finished |
| desc_park | output | 1 | Descriptor not processed, await restart |
| med_req | output | 1 | Medium request pending |
| med_op | output | 2 | Request kind (see R8) |
| med_offset | output | LBA_W+12 | Byte offset on the medium |
| med_addr | output | ADDR_W | Memory address of the request |
| med_len | output | LEN_W | Request length in bytes |
| med_ack | input | 1 | Medium finished the request |
| med_err | input | 1 | Medium reports failure with med_ack |
| busy | output | 1 | Drive busy state |
| drv_status | output | 8 | Drive status byte |
| irq | output | 1 | Disk completion interrupt pulse |
| pkt_ok | output | 1 | Optical packet command succeeded |
| dma_err | output | 1 | Disk DMA error pulse |
| pkt_err | output | 1 | Optical packet I/O error pulse |
| fatal | output | 1 | Illegal disk command seen, sticky |

## Verification
The bench uses the default parameters: 24-bit block addresses, 16-bit descriptor lengths, an 8-bit sector count and 16-bit packet sizes. With these values the all-ones address marker is a concrete 24-bit pattern. A single descriptor longer than the remaining count can drive the remaining count negative and finish the transfer early. Both the 512-byte and the 2048-byte offset scalings produce values well beyond 32 bits, so the full offset width is used.

// File: rtl/ide_dma_pkg.sv
package ide_dma_pkg;
  typedef enum logic [1:0] {CMD_RD = 2'd0, CMD_WR = 2'd1, CMD_TRIM = 2'd2, CMD_BAD = 2'd3} drv_cmd_e;
  typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_TRIM = 2'd2, OP_COPY = 2'd3} med_op_e;
  typedef enum logic [1:0] {ST_WAIT = 2'd0, ST_REQ = 2'd1, ST_HALT = 2'd2} seq_st_e;
  localparam logic [7:0] STAT_DONE = 8'h50;
endpackage

// File: rtl/ide_dma_size.sv
module ide_dma_size #(
  parameter int NSEC_W = 8,
  parameter int PKT_W  = 16,
  parameter int REM_W  = 19
) (
  input  logic                    is_optical,
  input  logic [NSEC_W-1:0]       sec_count,
  input  logic [PKT_W-1:0]        pkt_bytes,
  output logic signed [REM_W-1:0] total
);
  localparam int DISK_W = NSEC_W + 9;
  logic [DISK_W-1:0] disk_bytes;

  always_comb begin
    disk_bytes = {sec_count, 9'b0};
    if (is_optical) total = signed'(REM_W'(pkt_bytes));
    else            total = signed'(REM_W'(disk_bytes));
  end
endmodule

// File: rtl/ide_dma_offset.sv
module ide_dma_offset #(
  parameter int LBA_W = 24,
  parameter int IDX_W = 19,
  parameter int OFF_W = 36
) (
  input  logic             is_optical,
  input  logic [LBA_W-1:0] blk,
  input  logic [IDX_W-1:0] idx,
  output logic [OFF_W-1:0] off
);
  logic [OFF_W-1:0] base;

  always_comb begin
    if (is_optical) base = OFF_W'({blk, 11'b0});
    else            base = OFF_W'({blk, 9'b0});
    off = base + OFF_W'(idx);
  end
endmodule

// File: rtl/ide_dma_ctrl.sv
module ide_dma_ctrl
  import ide_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int LBA_W  = 24,
  parameter int REM_W  = 19,
  parameter int IDX_W  = 19,
  parameter int OFF_W  = 36
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    is_optical,
  input  logic [1:0]              cmd,
  input  logic [LBA_W-1:0]        start_sector,
  input  logic [LBA_W-1:0]        pkt_lba,
  input  logic signed [REM_W-1:0] total,
  input  logic                    desc_valid,
  input  logic [ADDR_W-1:0]       desc_addr,
  input  logic [LEN_W-1:0]        desc_len,
  input  logic [OFF_W-1:0]        cur_off,
  output logic                    optical_q,
  output logic [LBA_W-1:0]        blk_q,
  output logic [IDX_W-1:0]        idx,
  output logic                    kick,
  output logic                    desc_done,
  output logic                    desc_park,
  output logic                    med_req,
  output logic [1:0]              med_op,
  output logic [OFF_W-1:0]        med_offset,
  output logic [ADDR_W-1:0]       med_addr,
  output logic [LEN_W-1:0]        med_len,
  input  logic                    med_ack,
  input  logic                    med_err,
  output logic                    busy,
  output logic [7:0]              drv_status,
  output logic                    irq,
  output logic                    pkt_ok,
  output logic                    dma_err,
  output logic                    pkt_err,
  output logic                    fatal
);
  seq_st_e                 st;
  drv_cmd_e                cmd_q;
  logic                    active;
  logic                    nolba_q;
  logic                    copy_q;
  logic signed [REM_W-1:0] rem;
  logic signed [REM_W-1:0] len_ext;
  logic                    rem_le0;
  logic [LEN_W-1:0]        copy_len;
  med_op_e                 blk_op;

  always_comb begin
    len_ext  = signed'(REM_W'(desc_len));
    rem_le0  = rem[REM_W-1] || (rem == '0);
    copy_len = (rem < len_ext) ? rem[LEN_W-1:0] : desc_len;
    blk_op   = optical_q ? OP_RD : med_op_e'(cmd_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_WAIT;
      cmd_q      <= CMD_RD;
      active     <= 1'b0;
      nolba_q    <= 1'b0;
      copy_q     <= 1'b0;
      optical_q  <= 1'b0;
      blk_q      <= '0;
      rem        <= '0;
      idx        <= '0;
      kick       <= 1'b0;
      desc_done  <= 1'b0;
      desc_park  <= 1'b0;
      med_req    <= 1'b0;
      med_op     <= 2'd0;
      med_offset <= '0;
      med_addr   <= '0;
      med_len    <= '0;
      busy       <= 1'b0;
      drv_status <= 8'h00;
      irq        <= 1'b0;
      pkt_ok     <= 1'b0;
      dma_err    <= 1'b0;
      pkt_err    <= 1'b0;
      fatal      <= 1'b0;
    end else begin
      kick      <= 1'b0;
      desc_done <= 1'b0;
      desc_park <= 1'b0;
      irq       <= 1'b0;
      pkt_ok    <= 1'b0;
      dma_err   <= 1'b0;
      pkt_err   <= 1'b0;
      unique case (st)
        ST_WAIT: begin
          if (start) begin
            if (desc_valid) desc_park <= 1'b1;
            idx       <= '0;
            rem       <= total;
            active    <= 1'b1;
            busy      <= 1'b1;
            kick      <= 1'b1;
            optical_q <= is_optical;
            cmd_q     <= drv_cmd_e'(cmd);
            blk_q     <= is_optical ? pkt_lba : start_sector;
            nolba_q   <= &pkt_lba;
          end else if (desc_valid) begin
            if (!active) begin
              desc_park <= 1'b1;
            end else if (rem_le0) begin
              desc_done <= 1'b1;
              busy      <= 1'b0;
              active    <= 1'b0;
              if (optical_q) pkt_ok <= 1'b1;
              else begin
                irq        <= 1'b1;
                drv_status <= STAT_DONE;
              end
            end else if (desc_len == '0) begin
              desc_done <= 1'b1;
              busy      <= 1'b0;
            end else if (!optical_q && cmd_q == CMD_BAD) begin
              st    <= ST_HALT;
              fatal <= 1'b1;
            end else begin
              med_req    <= 1'b1;
              med_offset <= cur_off;
              med_addr   <= desc_addr;
              st         <= ST_REQ;
              if (optical_q && nolba_q) begin
                med_op  <= OP_COPY;
                med_len <= copy_len;
                copy_q  <= 1'b1;
              end else begin
                med_op  <= blk_op;
                med_len <= desc_len;
                rem     <= rem - len_ext;
                idx     <= idx + IDX_W'(desc_len);
                copy_q  <= 1'b0;
              end
            end
          end
        end
        ST_REQ: begin
          if (med_ack) begin
            med_req   <= 1'b0;
            st        <= ST_WAIT;
            desc_done <= 1'b1;
            busy      <= 1'b0;
            if (med_err) begin
              active <= 1'b0;
              if (optical_q) pkt_err <= 1'b1;
              else           dma_err <= 1'b1;
            end else if (copy_q) begin
              active <= 1'b0;
              pkt_ok <= 1'b1;
            end else if (rem_le0) begin
              active <= 1'b0;
              if (optical_q) pkt_ok <= 1'b1;
              else begin
                irq        <= 1'b1;
                drv_status <= STAT_DONE;
              end
            end
          end
        end
        default: begin
          fatal <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/ide_dma_seq.sv
module ide_dma_seq #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int LBA_W  = 24,
  parameter int NSEC_W = 8,
  parameter int PKT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  is_optical,
  input  logic [1:0]            cmd,
  input  logic [NSEC_W-1:0]     sec_count,
  input  logic [PKT_W-1:0]      pkt_bytes,
  input  logic [LBA_W-1:0]      start_sector,
  input  logic [LBA_W-1:0]      pkt_lba,
  input  logic                  desc_valid,
  input  logic [ADDR_W-1:0]     desc_addr,
  input  logic [LEN_W-1:0]      desc_len,
  output logic                  kick,
  output logic                  desc_done,
  output logic                  desc_park,
  output logic                  med_req,
  output logic [1:0]            med_op,
  output logic [LBA_W+12-1:0]   med_offset,
  output logic [ADDR_W-1:0]     med_addr,
  output logic [LEN_W-1:0]      med_len,
  input  logic                  med_ack,
  input  logic                  med_err,
  output logic                  busy,
  output logic [7:0]            drv_status,
  output logic                  irq,
  output logic                  pkt_ok,
  output logic                  dma_err,
  output logic                  pkt_err,
  output logic                  fatal
);
  localparam int SZ_DISK = NSEC_W + 9;
  localparam int SZ_OTH  = (PKT_W > LEN_W) ? PKT_W : LEN_W;
  localparam int REM_W   = ((SZ_DISK > SZ_OTH) ? SZ_DISK : SZ_OTH) + 2;
  localparam int IDX_W   = REM_W;
  localparam int OFF_W   = LBA_W + 12;

  logic signed [REM_W-1:0] total;
  logic [OFF_W-1:0]        cur_off;
  logic                    optical_q;
  logic [LBA_W-1:0]        blk_q;
  logic [IDX_W-1:0]        idx;

  ide_dma_size #(.NSEC_W(NSEC_W), .PKT_W(PKT_W), .REM_W(REM_W)) u_size (
    .is_optical(is_optical), .sec_count(sec_count), .pkt_bytes(pkt_bytes), .total(total)
  );

  ide_dma_offset #(.LBA_W(LBA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_off (
    .is_optical(optical_q), .blk(blk_q), .idx(idx), .off(cur_off)
  );

  ide_dma_ctrl #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LBA_W(LBA_W),
    .REM_W(REM_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .is_optical(is_optical), .cmd(cmd),
    .start_sector(start_sector), .pkt_lba(pkt_lba), .total(total),
    .desc_valid(desc_valid), .desc_addr(desc_addr), .desc_len(desc_len),
    .cur_off(cur_off), .optical_q(optical_q), .blk_q(blk_q), .idx(idx),
    .kick(kick), .desc_done(desc_done), .desc_park(desc_park),
    .med_req(med_req), .med_op(med_op), .med_offset(med_offset),
    .med_addr(med_addr), .med_len(med_len), .med_ack(med_ack), .med_err(med_err),
    .busy(busy), .drv_status(drv_status), .irq(irq), .pkt_ok(pkt_ok),
    .dma_err(dma_err), .pkt_err(pkt_err), .fatal(fatal)
  );
endmodule

// File: rtl/ide_dma_seq_chk.sv
module ide_dma_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int LBA_W  = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              kick,
  input logic              desc_done,
  input logic              desc_park,
  input logic              med_req,
  input logic [1:0]        med_op,
  input logic [LBA_W+11:0] med_offset,
  input logic [ADDR_W-1:0] med_addr,
  input logic [LEN_W-1:0]  med_len,
  input logic              med_ack,
  input logic              busy,
  input logic [7:0]        drv_status,
  input logic              irq,
  input logic              pkt_ok,
  input logic              dma_err,
  input logic              pkt_err,
  input logic              fatal
);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (med_req && !med_ack) |=> (med_req && $stable(med_offset) && $stable(med_addr)
                               && $stable(med_len) && $stable(med_op)));
  // R12
  ack_done_chk: assert property (@(posedge clk) disable iff (rst)
    (med_req && med_ack) |=> (desc_done && !med_req));
  // R4
  irq_status_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (drv_status == 8'h50 && desc_done && !busy));
  // R11
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq, pkt_ok, dma_err, pkt_err}));
  // R11
  err_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_err || pkt_err) |-> (desc_done && !busy && !med_req));
  // R3
  park_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    desc_park |-> (!desc_done && !med_req));
  // R9
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fatal |=> (fatal && !med_req && !desc_done));
  // R2
  kick_busy_chk: assert property (@(posedge clk) disable iff (rst)
    kick |-> (busy && !desc_done));
endmodule

bind ide_dma_seq ide_dma_seq_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LBA_W(LBA_W)) u_chk (
  .clk(clk), .rst(rst), .kick(kick), .desc_done(desc_done), .desc_park(desc_park),
  .med_req(med_req), .med_op(med_op), .med_offset(med_offset), .med_addr(med_addr),
  .med_len(med_len), .med_ack(med_ack), .busy(busy), .drv_status(drv_status),
  .irq(irq), .pkt_ok(pkt_ok), .dma_err(dma_err), .pkt_err(pkt_err), .fatal(fatal)
);

// File: tb/ide_dma_seq_bench.sv
module ide_dma_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int LBA_W  = 24;
  localparam int NSEC_W = 8;
  localparam int PKT_W  = 16;
  localparam int OFF_W  = LBA_W + 12;
  localparam int RESP_LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, is_optical = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic [NSEC_W-1:0] sec_count = '0;
  logic [PKT_W-1:0] pkt_bytes = '0;
  logic [LBA_W-1:0] start_sector = '0, pkt_lba = '0;
  logic desc_valid = 1'b0;
  logic [ADDR_W-1:0] desc_addr = '0;
  logic [LEN_W-1:0] desc_len = '0;
  logic med_ack = 1'b0, med_err = 1'b0;
  logic kick, desc_done, desc_park, med_req, busy, irq, pkt_ok, dma_err, pkt_err, fatal;
  logic [1:0] med_op;
  logic [OFF_W-1:0] med_offset;
  logic [ADDR_W-1:0] med_addr;
  logic [LEN_W-1:0] med_len;
  logic [7:0] drv_status;

  ide_dma_seq u_ide_dma_seq (
    .clk(clk), .rst(rst), .start(start), .is_optical(is_optical), .cmd(cmd),
    .sec_count(sec_count), .pkt_bytes(pkt_bytes), .start_sector(start_sector),
    .pkt_lba(pkt_lba), .desc_valid(desc_valid), .desc_addr(desc_addr), .desc_len(desc_len),
    .kick(kick), .desc_done(desc_done), .desc_park(desc_park), .med_req(med_req),
    .med_op(med_op), .med_offset(med_offset), .med_addr(med_addr), .med_len(med_len),
    .med_ack(med_ack), .med_err(med_err), .busy(busy), .drv_status(drv_status),
    .irq(irq), .pkt_ok(pkt_ok), .dma_err(dma_err), .pkt_err(pkt_err), .fatal(fatal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  bit resp_err = 1'b0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_st = 0;
  bit m_active = 0, m_opt = 0, m_nolba = 0, m_copy = 0;
  int m_cmd = 0;
  longint m_blk = 0, m_rem = 0, m_idx = 0;
  bit e_kick = 0, e_done = 0, e_park = 0, e_irq = 0, e_pok = 0, e_derr = 0, e_perr = 0;
  bit e_fatal = 0, e_busy = 0, e_req = 0;
  int e_op = 0, e_status = 0;
  longint e_off = 0, e_addr = 0, e_len = 0;

  task automatic model_finish();
    e_done = 1; e_busy = 0; m_active = 0;
    if (m_opt) e_pok = 1;
    else begin e_irq = 1; e_status = 8'h50; end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_active = 0; m_opt = 0; m_nolba = 0; m_copy = 0; m_cmd = 0;
      m_blk = 0; m_rem = 0; m_idx = 0;
      e_kick = 0; e_done = 0; e_park = 0; e_irq = 0; e_pok = 0; e_derr = 0; e_perr = 0;
      e_fatal = 0; e_busy = 0; e_req = 0; e_status = 0;
    end else begin
      e_kick = 0; e_done = 0; e_park = 0; e_irq = 0; e_pok = 0; e_derr = 0; e_perr = 0;
      if (m_st == 0) begin
        if (start) begin
          if (desc_valid) e_park = 1;
          m_idx = 0;
          m_rem = is_optical ? longint'(pkt_bytes) : longint'(sec_count) * 512;
          m_active = 1; e_busy = 1; e_kick = 1;
          m_opt = is_optical; m_cmd = int'(cmd);
          m_blk = is_optical ? longint'(pkt_lba) : longint'(start_sector);
          m_nolba = (pkt_lba == {LBA_W{1'b1}});
        end else if (desc_valid) begin
          if (!m_active) e_park = 1;
          else if (m_rem <= 0) model_finish();
          else if (desc_len == 0) begin e_done = 1; e_busy = 0; end
          else if (!m_opt && m_cmd == 3) begin m_st = 2; e_fatal = 1; end
          else begin
            e_req = 1; e_addr = longint'(desc_addr);
            e_off = (m_blk * (m_opt ? 2048 : 512) + m_idx) & ((64'd1 << OFF_W) - 1);
            if (m_opt && m_nolba) begin
              e_op = 3; m_copy = 1;
              e_len = (m_rem < longint'(desc_len)) ? m_rem : longint'(desc_len);
            end else begin
              e_op = m_opt ? 0 : m_cmd; m_copy = 0;
              e_len = longint'(desc_len);
              m_rem = m_rem - longint'(desc_len);
              m_idx = m_idx + longint'(desc_len);
            end
            m_st = 1;
          end
        end
      end else if (m_st == 1) begin
        if (med_ack) begin
          e_req = 0; m_st = 0; e_done = 1; e_busy = 0;
          if (med_err) begin
            m_active = 0;
            if (m_opt) e_perr = 1; else e_derr = 1;
          end else if (m_copy) begin
            m_active = 0; e_pok = 1;
          end else if (m_rem <= 0) begin
            m_active = 0;
            if (m_opt) e_pok = 1; else begin e_irq = 1; e_status = 8'h50; end
          end
        end
      end
    end
  end

  // per-clock comparison and event counters
  int n_irq = 0, n_pok = 0, n_park = 0, n_done = 0, n_derr = 0, n_perr = 0, n_req = 0;
  longint last_len = 0, last_off = 0;
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 busy", busy, e_busy);
      chk("R2 kick", kick, e_kick);
      chk("R3 desc_park", desc_park, e_park);
      chk("R5 desc_done", desc_done, e_done);
      chk("R4 irq", irq, e_irq);
      chk("R4 pkt_ok", pkt_ok, e_pok);
      chk("R4 drv_status", drv_status, e_status);
      chk("R11 dma_err", dma_err, e_derr);
      chk("R11 pkt_err", pkt_err, e_perr);
      chk("R9 fatal", fatal, e_fatal);
      chk("R12 med_req", med_req, e_req);
      if (e_req) begin
        chk("R6 med_offset", med_offset, e_off);
        chk("R7 med_addr", med_addr, e_addr);
        chk(e_op == 3 ? "R10 med_len" : "R7 med_len", med_len, e_len);
        chk("R8 med_op", med_op, e_op);
      end
      n_irq += irq; n_pok += pkt_ok; n_park += desc_park; n_done += desc_done;
      n_derr += dma_err; n_perr += pkt_err;
      if (med_req) begin last_len = med_len; last_off = med_offset; end
    end
  end

  // medium responder
  int lat_cnt = 0;
  always @(negedge clk) begin
    if (rst) begin
      med_ack = 0; med_err = 0; lat_cnt = 0;
    end else if (med_ack) begin
      med_ack = 0; med_err = 0; lat_cnt = 0;
    end else if (med_req) begin
      lat_cnt++;
      if (lat_cnt >= RESP_LAT) begin med_ack = 1; med_err = resp_err; end
    end
  end

  task automatic do_start(input bit opt, input int c, input int nsec, input int pkt,
                          input longint sec, input longint lba, input bit with_desc);
    @(negedge clk);
    start = 1; is_optical = opt; cmd = 2'(c); sec_count = NSEC_W'(nsec);
    pkt_bytes = PKT_W'(pkt); start_sector = LBA_W'(sec); pkt_lba = LBA_W'(lba);
    desc_valid = with_desc; desc_len = 16'd512;
    @(negedge clk);
    start = 0; desc_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_desc(input longint addr, input int len);
    @(negedge clk);
    desc_valid = 1; desc_addr = ADDR_W'(addr); desc_len = LEN_W'(len);
    @(negedge clk);
    desc_valid = 0;
    repeat (RESP_LAT + 5) @(negedge clk);
  endtask

  initial begin
    int b_irq, b_pok, b_park, b_done, b_derr, b_perr;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 med_req", med_req, 0);
    chk("R1 drv_status", drv_status, 0); chk("R1 fatal", fatal, 0);
    chk("R1 irq", irq, 0);
    rst = 0;
    repeat (2) @(negedge clk);

    // R3 descriptor before any start is parked
    b_park = n_park; b_done = n_done;
    send_desc(32'h100, 512);
    chk("R3 park before start", n_park - b_park, 1);
    chk("R3 no done when parked", n_done - b_done, 0);

    // R4 R6 disk read of two sectors in two chunks
    b_irq = n_irq; b_done = n_done;
    do_start(0, 0, 2, 0, 100, 0, 0);
    send_desc(32'h1000, 512);
    chk("R6 first disk offset", last_off, 100 * 512);
    send_desc(32'h2000, 512);
    chk("R6 second disk offset", last_off, 100 * 512 + 512);
    chk("R4 disk irq count", n_irq - b_irq, 1);
    chk("R4 done count", n_done - b_done, 2);
    chk("R4 status ready", drv_status, 8'h50);
    b_park = n_park;
    send_desc(32'h3000, 512);
    chk("R4 inactive after completion", n_park - b_park, 1);

    // R5 zero-length descriptor then write
    b_done = n_done; b_irq = n_irq;
    do_start(0, 1, 1, 0, 7, 0, 0);
    send_desc(32'h4000, 0);
    chk("R5 zero length done", n_done - b_done, 1);
    chk("R5 busy dropped", busy, 0);
    chk("R5 no completion", n_irq - b_irq, 0);
    send_desc(32'h4000, 512);
    chk("R5 still active then completes", n_irq - b_irq, 1);

    // R7 trim overshoot: remaining goes negative
    b_irq = n_irq;
    do_start(0, 2, 1, 0, 9, 0, 0);
    send_desc(32'h5000, 600);
    chk("R7 overshoot completes", n_irq - b_irq, 1);

    // R7 partial chunk keeps transfer open
    b_irq = n_irq;
    do_start(0, 0, 3, 0, 20, 0, 0);
    send_desc(32'h6000, 1024);
    chk("R7 partial no irq", n_irq - b_irq, 0);
    send_desc(32'h7000, 512);
    chk("R7 index advanced", last_off, 20 * 512 + 1024);
    chk("R7 final completion", n_irq - b_irq, 1);

    // R6 R4 optical block transfer
    b_pok = n_pok;
    do_start(1, 0, 0, 4096, 0, 5, 0);
    send_desc(32'h8000, 2048);
    chk("R6 optical offset", last_off, 5 * 2048);
    send_desc(32'h9000, 2048);
    chk("R6 optical second offset", last_off, 5 * 2048 + 2048);
    chk("R4 optical pkt_ok", n_pok - b_pok, 1);

    // R10 direct copy, length limited by remaining
    b_pok = n_pok; b_done = n_done;
    do_start(1, 0, 0, 100, 0, 24'hFFFFFF, 0);
    send_desc(32'hA000, 300);
    chk("R10 copy length min rem", last_len, 100);
    chk("R10 copy pkt_ok", n_pok - b_pok, 1);
    chk("R10 copy done", n_done - b_done, 1);
    b_pok = n_pok;
    do_start(1, 0, 0, 300, 0, 24'hFFFFFF, 0);
    send_desc(32'hB000, 100);
    chk("R10 copy length min desc", last_len, 100);
    chk("R10 copy ends transfer", n_pok - b_pok, 1);

    // R11 disk error and optical error
    resp_err = 1;
    b_derr = n_derr; b_park = n_park;
    do_start(0, 0, 2, 0, 3, 0, 0);
    send_desc(32'hC000, 512);
    chk("R11 dma_err", n_derr - b_derr, 1);
    send_desc(32'hC200, 512);
    chk("R11 inactive after error", n_park - b_park, 1);
    b_perr = n_perr;
    do_start(1, 0, 0, 2048, 0, 2, 0);
    send_desc(32'hD000, 2048);
    chk("R11 pkt_err", n_perr - b_perr, 1);
    resp_err = 0;

    // R3 start and descriptor in the same cycle
    b_park = n_park;
    do_start(0, 0, 1, 0, 4, 0, 1);
    chk("R3 same-cycle park", n_park - b_park, 1);
    send_desc(32'hE000, 512);

    // R9 illegal disk command
    b_done = n_done;
    do_start(0, 3, 1, 0, 1, 0, 0);
    send_desc(32'hF000, 512);
    chk("R9 fatal raised", fatal, 1);
    send_desc(32'hF000, 512);
    chk("R9 ignored while fatal", n_done - b_done, 0);
    chk("R9 fatal sticky", fatal, 1);
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    chk("R1 fatal cleared", fatal, 0);
    chk("R1 busy cleared", busy, 0);
    rst = 0;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule